// File: doc/BRIEF.md
# Shared Work-Stealing Task Scheduler

A single shared unit that keeps one bounded task queue for every logical core and serves enqueue, dequeue and prefetch requests arriving on one request port per core. Task tuples are opaque words: the unit stores and returns them without looking inside. A core that dequeues gets back its own most recently enqueued task. If its own queue is empty, the unit takes the oldest task from another core's queue. Because all queues sit next to each other, the unit knows which ones are empty within the same cycle. It therefore picks a victim in the grant cycle and can tell at once when no work is left anywhere.

Each core raises its request and holds it until it sees its grant bit. Exactly one request is granted per cycle, in round-robin order. The result of a granted request appears on a shared response bus in the following cycle, tagged with the index of the core that was served. An enqueue into a full queue is refused and flagged as an overflow, so that software can spill tasks to memory. The completion output is high when every queue is empty and no core is still working on a task it dequeued.

Top module: `task_steal_sched`

## Requirements
- R1: An enqueue (op code 0) granted to core c stores the tuple in queue c only. Bit c of `q_nonempty` is 1 exactly when queue c holds at least one tuple.
- R2: A dequeue granted to core c while queue c is non-empty returns the tuple most recently stored in queue c (LIFO), with `rsp_hit`=1 and `rsp_stolen`=0.
- R3: Each queue holds at most DEPTH tuples. An enqueue into a full queue gives `rsp_overflow`=1 and `rsp_hit`=0, and it leaves the queue contents unchanged.
- R4: A dequeue granted to core c while queue c is empty removes the oldest tuple of the victim queue, with `rsp_hit`=1 and `rsp_stolen`=1.
- R5: The victim is the first non-empty queue in the order c+1, c+2, ... modulo NCORE.
- R6: Op codes 1 (dequeue) and 2 (prefetch) behave identically, including stealing and busy tracking. Op code 3 is also treated as a dequeue.
- R7: A dequeue granted while every queue is empty returns `rsp_hit`=0, `rsp_stolen`=0 and `rsp_overflow`=0.
- R8: At most one request is granted per cycle, and only to a requesting core. The search starts after the last granted index, so cores that request continuously are served in rotating index order, beginning at core 0 after reset.
- R9: A request granted in cycle t produces `rsp_valid`=1 in cycle t+1 with `rsp_core` equal to the granted index. With no grant, `rsp_valid` is 0 in the next cycle.
- R10: Core c is busy after its latest granted dequeue returned a tuple, and idle after its latest granted dequeue returned none. `all_done` is 1 exactly when every queue is empty and no core is busy.
- R11: During and right after reset, all queues are empty, no core is busy, `all_done`=1 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NCORE | Per-core request, held until granted |
| req_op | input | 2*NCORE | Per-core op code: 0 enqueue, 1 dequeue, 2 prefetch, 3 dequeue |
| req_task | input | NCORE*TW | Per-core tuple to enqueue |
| req_grant | output | NCORE | One-hot grant for this cycle (combinational) |
| rsp_valid | output | 1 | Response present for the previous cycle's grant |
| rsp_core | output | CW | Index of the core being answered |
| rsp_hit | output | 1 | A dequeue returned a tuple |
| rsp_stolen | output | 1 | The returned tuple came from another core's queue |
| rsp_overflow | output | 1 | An enqueue was refused because the queue was full |
| rsp_task | output | TW | Returned tuple, zero when `rsp_hit` is 0 |
| q_nonempty | output | NCORE | Per-queue non-empty status |
| all_done | output | 1 | No queued tuples and no busy core |

## Verification
On every cycle the assertions check the following. Grants are at most one-hot and go only to requesting cores. Every grant is answered in the next cycle with the right core index. No queue is pushed while full or popped while empty. A steal or an overflow is never reported together with a contradictory flag. A response that hands out a tuple is never accompanied by completion. The bench scenarios carry the checks that need a history of stored values. These are the LIFO order of own pops, that a thief takes the victim's oldest entry, the rotating order of victim search and of arbitration, that a refused enqueue does not change the queue, and the exact moment completion rises once the last busy core comes back empty-handed.

// File: rtl/tss_pkg.sv
// Package: shared op codes for the work-stealing task scheduler.
// Assumes a 2-bit op field per requesting core.
package tss_pkg;
    typedef enum logic [1:0] {
        OP_ENQ  = 2'd0,
        OP_DEQ  = 2'd1,
        OP_PREF = 2'd2,
        OP_ALT  = 2'd3
    } tss_op_e;
endpackage

// File: rtl/tss_rr_pick.sv
// Module: rotating priority picker.
// Finds the first set bit of cand, searching base+1, base+2, ... modulo N,
// with base itself checked last. Used both for request arbitration and
// for victim choice. Assumes N >= 2 and base < N.
module tss_rr_pick #(
    parameter int N  = 4,
    parameter int CW = $clog2(N)
) (
    input  logic [N-1:0]  cand,
    input  logic [CW-1:0] base,
    output logic          found,
    output logic [CW-1:0] idx
);
    // Purpose: scan candidates in rotating order and report the first hit.
    always_comb begin
        int j;
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= N; k++) begin
            j = (int'(base) + k) % N;
            if (!found && cand[j]) begin
                found = 1'b1;
                idx   = CW'(j);
            end
        end
    end

    // Purpose: a reported pick always points at a live candidate (R8, R5).
    always_comb begin
        if (found) begin
            assert_pick_live_R8: assert (cand[idx]);
        end
    end
endmodule

// File: rtl/tss_deque.sv
// Module: bounded double-ended task store for one core.
// The owner pushes and pops at the newest end; a thief pops at the oldest
// end. At most one action per cycle; the caller must not push when full
// nor pop when empty. Assumes DEPTH is a power of two, at least 2.
module tss_deque #(
    parameter int DEPTH = 4,
    parameter int TW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [TW-1:0] push_task,
    input  logic          pop_newest,
    input  logic          pop_oldest,
    output logic [TW-1:0] newest,
    output logic [TW-1:0] oldest,
    output logic          empty,
    output logic          full
);
    localparam int AW = $clog2(DEPTH);

    logic [TW-1:0] mem [DEPTH];
    logic [AW-1:0] head;
    logic [AW:0]   cnt;
    logic [AW-1:0] tail_idx;
    logic [AW-1:0] top_idx;

    assign tail_idx = head + cnt[AW-1:0];
    assign top_idx  = tail_idx - 1'b1;
    assign newest   = mem[top_idx];
    assign oldest   = mem[head];
    assign empty    = (cnt == '0);
    assign full     = (cnt == (AW+1)'(DEPTH));

    // Purpose: track the oldest position and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            cnt  <= '0;
        end else if (push) begin
            cnt <= cnt + 1'b1;
        end else if (pop_newest) begin
            cnt <= cnt - 1'b1;
        end else if (pop_oldest) begin
            head <= head + 1'b1;
            cnt  <= cnt - 1'b1;
        end
    end

    // Purpose: write the pushed tuple into the slot after the newest one.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[tail_idx] <= push_task;
        end
    end

    // Purpose: the scheduler never stores into a full queue (R3).
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // Purpose: pops only happen on a queue that holds something (R4).
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_newest || pop_oldest) |-> !empty);

    // Purpose: one queue action per cycle, as a single grant implies (R8).
    assert_single_action_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({push, pop_newest, pop_oldest}) <= 1);
endmodule

// File: rtl/task_steal_sched.sv
// Module: shared work-stealing task scheduler.
// Holds one bounded LIFO queue per core, grants one request per cycle in
// round-robin order, serves dequeues from the own queue or by stealing the
// oldest tuple of the next non-empty queue, refuses enqueues into a full
// queue, and reports global completion. Assumes each requester holds its
// request until granted and NCORE >= 2, DEPTH a power of two >= 2.
module task_steal_sched
    import tss_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int DEPTH = 4,
    parameter int TW    = 16,
    parameter int CW    = $clog2(NCORE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCORE-1:0]   req_valid,
    input  logic [2*NCORE-1:0] req_op,
    input  logic [NCORE*TW-1:0] req_task,
    output logic [NCORE-1:0]   req_grant,
    output logic               rsp_valid,
    output logic [CW-1:0]      rsp_core,
    output logic               rsp_hit,
    output logic               rsp_stolen,
    output logic               rsp_overflow,
    output logic [TW-1:0]      rsp_task,
    output logic [NCORE-1:0]   q_nonempty,
    output logic               all_done
);
    logic [CW-1:0]    rr_last;
    logic             gnt_found;
    logic [CW-1:0]    gnt_idx;
    logic             vic_found;
    logic [CW-1:0]    vic_idx;
    logic [1:0]       gnt_op;
    logic [TW-1:0]    gnt_task;
    logic             gnt_enq;
    logic             gnt_deq;
    logic             own_has;
    logic [NCORE-1:0] q_full;
    logic [NCORE-1:0] busy;
    logic [TW-1:0]    newest_v [NCORE];
    logic [TW-1:0]    oldest_v [NCORE];
    logic             nx_hit;
    logic             nx_stolen;
    logic             nx_ovf;
    logic [TW-1:0]    nx_task;

    // Request arbitration: search starts after the last granted core.
    tss_rr_pick #(.N(NCORE), .CW(CW)) u_arb (
        .cand  (req_valid),
        .base  (rr_last),
        .found (gnt_found),
        .idx   (gnt_idx)
    );

    // Victim choice: search starts after the granted core.
    tss_rr_pick #(.N(NCORE), .CW(CW)) u_vic (
        .cand  (q_nonempty),
        .base  (gnt_idx),
        .found (vic_found),
        .idx   (vic_idx)
    );

    assign gnt_op   = req_op[int'(gnt_idx)*2 +: 2];
    assign gnt_task = req_task[int'(gnt_idx)*TW +: TW];
    assign gnt_enq  = gnt_found && (gnt_op == OP_ENQ);
    assign gnt_deq  = gnt_found && (gnt_op != OP_ENQ);
    assign own_has  = q_nonempty[gnt_idx];

    // One queue per core with its push, own-pop and steal strobes.
    for (genvar c = 0; c < NCORE; c++) begin : g_core
        logic sel;
        logic emp;
        assign sel          = gnt_found && (gnt_idx == CW'(c));
        assign req_grant[c] = sel;
        assign q_nonempty[c] = ~emp;

        tss_deque #(.DEPTH(DEPTH), .TW(TW)) u_q (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (sel && gnt_enq && !q_full[c]),
            .push_task  (gnt_task),
            .pop_newest (sel && gnt_deq && own_has),
            .pop_oldest (gnt_deq && !own_has && vic_found && (vic_idx == CW'(c))),
            .newest     (newest_v[c]),
            .oldest     (oldest_v[c]),
            .empty      (emp),
            .full       (q_full[c])
        );
    end

    // Purpose: form the response for the request granted this cycle.
    always_comb begin
        nx_hit    = gnt_deq && (own_has || vic_found);
        nx_stolen = gnt_deq && !own_has && vic_found;
        nx_ovf    = gnt_enq && q_full[gnt_idx];
        nx_task   = '0;
        if (nx_hit) begin
            nx_task = own_has ? newest_v[gnt_idx] : oldest_v[vic_idx];
        end
    end

    // Purpose: register the response one cycle after the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_core     <= '0;
            rsp_hit      <= 1'b0;
            rsp_stolen   <= 1'b0;
            rsp_overflow <= 1'b0;
            rsp_task     <= '0;
        end else begin
            rsp_valid    <= gnt_found;
            rsp_core     <= gnt_idx;
            rsp_hit      <= nx_hit;
            rsp_stolen   <= nx_stolen;
            rsp_overflow <= nx_ovf;
            rsp_task     <= nx_task;
        end
    end

    // Purpose: remember the last granted core for round-robin order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_last <= CW'(NCORE - 1);
        end else if (gnt_found) begin
            rr_last <= gnt_idx;
        end
    end

    // Purpose: a core is busy when its latest dequeue handed it a tuple.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0;
        end else if (gnt_deq) begin
            busy[gnt_idx] <= nx_hit;
        end
    end

    assign all_done = ~|q_nonempty && ~|busy;

    // Purpose: grants are at most one-hot and only to requesters (R8).
    always_comb begin
        assert_one_grant_R8: assert ($onehot0(req_grant) && ((req_grant & ~req_valid) == '0));
    end

    // Purpose: each grant is answered in the next cycle for that core (R9).
    assert_rsp_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_found |=> (rsp_valid && rsp_core == $past(gnt_idx)));

    // Purpose: no response without a grant in the previous cycle (R9).
    assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_found |=> !rsp_valid);

    // Purpose: a stolen tuple is always a delivered tuple (R4).
    assert_steal_is_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stolen |-> rsp_hit);

    // Purpose: a refused enqueue delivers nothing (R3).
    assert_ovf_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_overflow |-> (!rsp_hit && !rsp_stolen));

    // Purpose: handing out a tuple makes the receiver busy, so not done (R10).
    assert_hit_not_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !all_done);
endmodule

// File: tb/task_steal_sched_tb.sv
module task_steal_sched_tb;
    localparam int NC = 4;
    localparam int DP = 4;
    localparam int TW = 16;
    localparam int CW = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NC-1:0]      req_valid = '0;
    logic [2*NC-1:0]    req_op = '0;
    logic [NC*TW-1:0]   req_task = '0;
    logic [NC-1:0]      req_grant;
    logic               rsp_valid;
    logic [CW-1:0]      rsp_core;
    logic               rsp_hit;
    logic               rsp_stolen;
    logic               rsp_overflow;
    logic [TW-1:0]      rsp_task;
    logic [NC-1:0]      q_nonempty;
    logic               all_done;

    int n_chk = 0;
    int n_bad = 0;
    bit busy_m [NC];
    logic [TW-1:0] mq [NC][$];

    task_steal_sched #(.NCORE(NC), .DEPTH(DP), .TW(TW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_task(req_task), .req_grant(req_grant), .rsp_valid(rsp_valid),
        .rsp_core(rsp_core), .rsp_hit(rsp_hit), .rsp_stolen(rsp_stolen),
        .rsp_overflow(rsp_overflow), .rsp_task(rsp_task),
        .q_nonempty(q_nonempty), .all_done(all_done)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] m_nonempty();
        logic [NC-1:0] v = '0;
        for (int i = 0; i < NC; i++) v[i] = (mq[i].size() > 0);
        return v;
    endfunction

    function automatic bit m_done();
        bit d = 1'b1;
        for (int i = 0; i < NC; i++) if (mq[i].size() > 0 || busy_m[i]) d = 1'b0;
        return d;
    endfunction

    // One request from core c; model update, drive, then check the response.
    task automatic do_op(input int c, input logic [1:0] o, input logic [TW-1:0] d);
        bit e_hit = 0, e_stl = 0, e_ovf = 0;
        logic [TW-1:0] e_data = '0;
        string tag;
        if (o == 2'd0) begin
            if (mq[c].size() == DP) begin e_ovf = 1; tag = "R3"; end
            else begin mq[c].push_back(d); tag = "R1"; end
        end else begin
            if (mq[c].size() > 0) begin
                e_hit = 1; e_data = mq[c].pop_back(); tag = "R2";
            end else begin
                tag = "R7";
                for (int k = 1; k <= NC; k++) begin
                    int j = (c + k) % NC;
                    if (!e_hit && mq[j].size() > 0) begin
                        e_hit = 1; e_stl = 1; e_data = mq[j].pop_front(); tag = "R4/R5";
                    end
                end
            end
            busy_m[c] = e_hit;
            if (o == 2'd2) tag = {tag, " R6"};
        end
        @(negedge clk);
        req_valid = '0;
        req_valid[c] = 1'b1;
        req_op[c*2 +: 2] = o;
        req_task[c*TW +: TW] = d;
        @(negedge clk);
        chk(rsp_valid == 1'b1, "R9 valid", 32'(rsp_valid), 1);
        chk(rsp_core == CW'(c), "R9 core", 32'(rsp_core), 32'(c));
        chk(rsp_hit == e_hit, {tag, " hit"}, 32'(rsp_hit), 32'(e_hit));
        chk(rsp_stolen == e_stl, {tag, " stolen"}, 32'(rsp_stolen), 32'(e_stl));
        chk(rsp_overflow == e_ovf, {tag, " overflow"}, 32'(rsp_overflow), 32'(e_ovf));
        if (e_hit) chk(rsp_task == e_data, {tag, " task"}, 32'(rsp_task), 32'(e_data));
        chk(q_nonempty == m_nonempty(), "R1 nonempty", 32'(q_nonempty), 32'(m_nonempty()));
        chk(all_done == m_done(), "R10 all_done", 32'(all_done), 32'(m_done()));
        req_valid = '0;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int exp_core;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NC; i++) busy_m[i] = 0;
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R11 rsp_valid in reset", 32'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(q_nonempty == '0, "R11 empty", 32'(q_nonempty), 0);
        chk(all_done == 1'b1, "R11 all_done", 32'(all_done), 1);
        chk(rsp_valid == 1'b0, "R11 rsp_valid", 32'(rsp_valid), 0);

        // R8: every core requests continuously; grants rotate from core 0.
        req_op = {NC{2'd1}};
        req_valid = '1;
        for (int t = 0; t < 2 * NC; t++) begin
            @(negedge clk);
            exp_core = t % NC;
            chk($countones(req_grant) == 1, "R8 one grant", 32'($countones(req_grant)), 1);
            chk(rsp_core == CW'(exp_core), "R8 rotation", 32'(rsp_core), 32'(exp_core));
            chk(rsp_hit == 1'b0, "R7 empty under contention", 32'(rsp_hit), 0);
        end
        req_valid = '0;
        @(negedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9 idle", 32'(rsp_valid), 0);

        // R3: fill core 0 past capacity, then drain in LIFO order (R2).
        for (int i = 0; i <= DP; i++) do_op(0, 2'd0, TW'(16'h100 + i));
        for (int i = 0; i < DP; i++) do_op(0, 2'd1, '0);
        do_op(0, 2'd1, '0);

        // R4 R5 R6: steals take the oldest from the next non-empty queue.
        do_op(1, 2'd0, 16'hA001);
        do_op(1, 2'd0, 16'hA002);
        do_op(3, 2'd0, 16'hB001);
        do_op(2, 2'd2, '0);
        do_op(2, 2'd1, '0);
        do_op(0, 2'd3, '0);
        do_op(1, 2'd1, '0);
        do_op(0, 2'd1, '0);
        do_op(2, 2'd2, '0);
        do_op(3, 2'd1, '0);
        chk(all_done == 1'b1, "R10 done after drain", 32'(all_done), 1);

        // Random mix of enqueues, dequeues and prefetches.
        for (int n = 0; n < 500; n++) begin
            int c = int'($urandom_range(NC - 1));
            int r = int'($urandom_range(99));
            logic [1:0] o = (r < 45) ? 2'd0 : ((r < 75) ? 2'd1 : 2'd2);
            do_op(c, o, TW'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule